// File: doc/BRIEF.md
# Speculative Access Dependence Violation Detector

This block watches the memory accesses of a small group of speculative tasks and reports read-after-write ordering violations between them. Each tracked line holds two bit vectors per task: one marks the words the task has written speculatively, the other marks the words it read before writing them itself (exposed reads). Every access names a task, a line index and a word within the line. Task age is measured from a head pointer that names the oldest, nonspeculative task. The task IDs wrap around modulo the task count.

When a task writes, the block looks at every younger task. A younger task that holds an exposed read of the same datum consumed a stale value. The block then raises a one-cycle squash request that names the oldest such task, and the commit logic squashes that task and all younger ones. A granularity input chooses what counts as the same datum. With word granularity, only a matching word counts. With line granularity, any word of the line counts, so false sharing also gives a squash. When a task commits or is squashed, its bits are wiped through the clear port.

Top module: `spec_dep_detector`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, squash_valid is 0 and every tracking bit is clear.
- R2: A read records an exposed read only if the reading task has not yet written the datum (the word when word_mode=1, any word of the line when word_mode=0). A later write by an older task to a datum the younger task wrote first does not squash it.
- R3: A write (acc_valid=1, acc_write=1) by task W squashes a younger task S that holds an exposed read of the same word. squash_valid is 1 and squash_task equals S in the cycle after the write is sampled, for one cycle.
- R4: With word_mode=0, a write to any word of a line squashes a younger task with an exposed read on any word of that line (false sharing squashes).
- R5: With word_mode=1, a write to a word that a younger task did not read gives no squash, even when that task read another word of the same line.
- R6: Reads never raise a squash. Write-after-read and write-after-write orderings between tasks raise no squash.
- R7: Age is (id - head_task) mod NTASK, with NTASK a power of two. When several younger tasks violate at once, squash_task names the one with the smallest age.
- R8: Exposed reads held by the writer itself or by older tasks never cause a squash.
- R9: clr_valid with clr_task wipes all bits of that task on every line. A task cleared in the same cycle as a write is not squashed by that write.
- R10: A write by the head (nonspeculative) task is checked in the same way as any other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_mode | input | 1 | 1: word granularity, 0: line granularity |
| head_task | input | TW | ID of the oldest (nonspeculative) task |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1: write, 0: read |
| acc_task | input | TW | Task issuing the access |
| acc_line | input | LW | Line index |
| acc_word | input | WW | Word within the line |
| clr_valid | input | 1 | Wipe one task's bits |
| clr_task | input | TW | Task to wipe |
| squash_valid | output | 1 | Violation seen on the previous write |
| squash_task | output | TW | Oldest violating successor |

## Verification
The directed patterns pair a consumer read with a producer write to the same word, to another word of the same line in each granularity, and to a word the consumer had written first. Each pair separates a true dependence, false sharing and an ordering that is not a violation. Further cases move the head pointer so that the age order wraps and two successors violate together, which shows whether the oldest one is picked. A clear that lands in the same cycle as a write shows which of the two wins. A long run of random accesses, clears and head moves is then compared cycle by cycle against a behavioural model of the bit vectors.

// File: rtl/spec_dep_detector.sv
module spec_dep_detector #(
  parameter int NTASK = 4,
  parameter int NLINE = 8,
  parameter int NWORD = 4,
  localparam int TW = $clog2(NTASK),
  localparam int LW = $clog2(NLINE),
  localparam int WW = $clog2(NWORD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_mode,
  input  logic [TW-1:0] head_task,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [TW-1:0] acc_task,
  input  logic [LW-1:0] acc_line,
  input  logic [WW-1:0] acc_word,
  input  logic          clr_valid,
  input  logic [TW-1:0] clr_task,
  output logic          squash_valid,
  output logic [TW-1:0] squash_task
);
  logic [NWORD-1:0] wr_q [NLINE][NTASK];
  logic [NWORD-1:0] rd_q [NLINE][NTASK];

  logic [NWORD-1:0] own_wr;
  logic             own_written;
  logic [NTASK-1:0] viol;
  logic [TW-1:0]    w_age;
  logic             pick_v;
  logic [TW-1:0]    pick_t;

  assign own_wr      = wr_q[acc_line][acc_task];
  assign own_written = word_mode ? own_wr[acc_word] : |own_wr;
  assign w_age       = acc_task - head_task;

  always_comb begin
    for (int s = 0; s < NTASK; s++) begin
      logic [NWORD-1:0] rv;
      logic [TW-1:0]    sa;
      rv = rd_q[acc_line][s];
      sa = TW'(s) - head_task;
      viol[s] = acc_valid && acc_write && (sa > w_age)
                && (word_mode ? rv[acc_word] : |rv)
                && !(clr_valid && clr_task == TW'(s));
    end
  end

  always_comb begin
    pick_v = 1'b0;
    pick_t = '0;
    for (int k = NTASK - 1; k > 0; k--) begin
      logic [TW-1:0] id;
      id = head_task + TW'(k);
      if (viol[id]) begin
        pick_v = 1'b1;
        pick_t = id;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      squash_valid <= 1'b0;
      squash_task  <= '0;
      for (int l = 0; l < NLINE; l++)
        for (int t = 0; t < NTASK; t++) begin
          wr_q[l][t] <= '0;
          rd_q[l][t] <= '0;
        end
    end else begin
      squash_valid <= pick_v;
      squash_task  <= pick_t;
      for (int l = 0; l < NLINE; l++)
        for (int t = 0; t < NTASK; t++) begin
          if (acc_valid && acc_line == LW'(l) && acc_task == TW'(t)) begin
            if (acc_write)
              wr_q[l][t][acc_word] <= 1'b1;
            else if (!own_written)
              rd_q[l][t][acc_word] <= 1'b1;
          end
          if (clr_valid && clr_task == TW'(t)) begin
            wr_q[l][t] <= '0;
            rd_q[l][t] <= '0;
          end
        end
    end
  end
endmodule

module spec_dep_checker #(
  parameter int TW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [TW-1:0] acc_task,
  input logic [TW-1:0] head_task,
  input logic          squash_valid,
  input logic [TW-1:0] squash_task
);
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !squash_valid);

  assert_squash_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> !squash_valid);

  assert_reads_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> !squash_valid);

  assert_not_writer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> (!squash_valid || squash_task != $past(acc_task)));

  assert_younger_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> (!squash_valid ||
      TW'(squash_task - $past(head_task)) > TW'($past(acc_task) - $past(head_task))));
endmodule

bind spec_dep_detector spec_dep_checker #(.TW(TW)) chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_task(acc_task), .head_task(head_task),
  .squash_valid(squash_valid), .squash_task(squash_task));

// File: tb/sim_spec_dep_detector.sv
module sim_spec_dep_detector;
  localparam int NT = 4, NL = 8, NW = 4;
  logic clk = 0, rst_n = 0, word_mode = 1;
  logic [1:0] head_task = 0, acc_task = 0, clr_task = 0;
  logic acc_valid = 0, acc_write = 0, clr_valid = 0;
  logic [2:0] acc_line = 0;
  logic [1:0] acc_word = 0;
  logic squash_valid;
  logic [1:0] squash_task;
  int checks = 0, fails = 0;
  bit done = 0;

  bit mw [NL][NT][NW];
  bit mr [NL][NT][NW];
  bit exp_v = 0;
  int exp_t = 0;

  always #4 clk = ~clk;

  spec_dep_detector u0 (.clk, .rst_n, .word_mode, .head_task, .acc_valid, .acc_write,
    .acc_task, .acc_line, .acc_word, .clr_valid, .clr_task, .squash_valid, .squash_task);

  function automatic int age(int id);
    return (id - int'(head_task) + NT) % NT;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v = 0; exp_t = 0;
      foreach (mw[l, t, w]) begin mw[l][t][w] = 0; mr[l][t][w] = 0; end
    end else begin
      int best;
      bit seen;
      best = NT; exp_t = 0;
      if (acc_valid && acc_write)
        for (int s = 0; s < NT; s++) begin
          bit hit;
          hit = 0;
          for (int w = 0; w < NW; w++)
            if (mr[acc_line][s][w] && (!word_mode || w == int'(acc_word))) hit = 1;
          if (hit && age(s) > age(int'(acc_task)) && !(clr_valid && int'(clr_task) == s)
              && age(s) < best) begin
            best = age(s); exp_t = s;
          end
        end
      exp_v = (best < NT);
      if (acc_valid) begin
        if (acc_write) mw[acc_line][acc_task][acc_word] = 1;
        else begin
          seen = 0;
          for (int w = 0; w < NW; w++)
            if (mw[acc_line][acc_task][w] && (!word_mode || w == int'(acc_word))) seen = 1;
          if (!seen) mr[acc_line][acc_task][acc_word] = 1;
        end
      end
      if (clr_valid)
        for (int l = 0; l < NL; l++)
          for (int w = 0; w < NW; w++) begin
            mw[l][clr_task][w] = 0; mr[l][clr_task][w] = 0;
          end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (squash_valid !== exp_v || (exp_v && int'(squash_task) != exp_t)) begin
      fails++;
      $display("FAIL R7 model: got v=%0b t=%0d expected v=%0b t=%0d",
               squash_valid, squash_task, exp_v, exp_t);
    end
  end

  task automatic acc(input bit wr, input int t, input int l, input int w);
    acc_valid = 1; acc_write = wr; acc_task = 2'(t); acc_line = 3'(l); acc_word = 2'(w);
    @(posedge clk); @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic clr(input int t);
    clr_valid = 1; clr_task = 2'(t);
    @(posedge clk); @(negedge clk);
    clr_valid = 0;
  endtask

  task automatic expect_sq(input bit v, input int t, input string req);
    checks++;
    if (squash_valid !== v || (v && int'(squash_task) != t)) begin
      fails++;
      $display("FAIL %s: got v=%0b t=%0d expected v=%0b t=%0d", req, squash_valid, squash_task, v, t);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_sq(0, 0, "R1");
    rst_n = 1;
    @(negedge clk);
    expect_sq(0, 0, "R1");

    acc(0, 2, 1, 0); acc(1, 1, 1, 0); expect_sq(1, 2, "R3");
    @(negedge clk); expect_sq(0, 0, "R3 one cycle");
    clr(2);

    acc(0, 2, 2, 1); acc(1, 0, 2, 3); expect_sq(0, 0, "R5");
    word_mode = 0;
    acc(1, 0, 2, 3); expect_sq(1, 2, "R4");
    word_mode = 1; clr(2); clr(0);

    acc(1, 3, 3, 0); acc(0, 3, 3, 0); acc(1, 1, 3, 0); expect_sq(0, 0, "R2");

    acc(1, 3, 4, 0); acc(1, 1, 4, 0); expect_sq(0, 0, "R6 waw");
    acc(0, 1, 4, 2); expect_sq(0, 0, "R6 read");
    acc(0, 1, 4, 3); acc(1, 3, 4, 3); expect_sq(0, 0, "R6 war");
    clr(1); clr(3);

    acc(0, 0, 5, 0); acc(1, 2, 5, 0); expect_sq(0, 0, "R8");
    clr(0); clr(2);

    acc(0, 3, 6, 0); acc(0, 2, 6, 0);
    head_task = 1;
    acc(1, 1, 6, 0); expect_sq(1, 2, "R7 oldest");
    head_task = 3;
    acc(1, 0, 6, 0); expect_sq(1, 2, "R7 wrap");
    clr(2); clr(3);
    head_task = 0;

    acc(0, 2, 7, 1); clr(2); acc(1, 1, 7, 1); expect_sq(0, 0, "R9 clear");
    acc(0, 2, 0, 0);
    clr_valid = 1; clr_task = 2;
    acc(1, 1, 0, 0); clr_valid = 0;
    expect_sq(0, 0, "R9 same cycle");

    acc(0, 1, 1, 2); acc(1, 0, 1, 2); expect_sq(1, 1, "R10");
    clr(0); clr(1);

    for (int i = 0; i < 600; i++) begin
      acc_valid = 1'($urandom_range(0, 3) != 0);
      acc_write = 1'($urandom_range(0, 2) == 0);
      acc_task  = 2'($urandom);
      acc_line  = 3'($urandom_range(0, 1));
      acc_word  = 2'($urandom);
      clr_valid = 1'($urandom_range(0, 7) == 0);
      clr_task  = 2'($urandom);
      if ($urandom_range(0, 15) == 0) head_task = 2'($urandom);
      if ($urandom_range(0, 31) == 0) word_mode = ~word_mode;
      @(posedge clk); @(negedge clk);
    end
    acc_valid = 0; clr_valid = 0;
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule